// File: doc/BRIEF.md
# DAC Load Control Register Unit

This block sits between a processor's register bus and a 12-bit DAC core. It holds two 12-bit registers: a staging register that software fills, and an output register whose value normally drives the DAC code. A 3-bit mode field decides when the staged value moves into the output register. The transfer can happen on a software write to the staging register, on a rising edge of an external load strobe, or on a falling edge of that strobe. A square-wave mode leaves both registers alone and uses the strobe polarity to choose which register drives the DAC code.

The external strobe is asynchronous. It passes through a synchronizer, and its edges are then found by comparing the synchronized level with its value one clock earlier. Each edge acts exactly once. A pin alternate-function enable tells the port logic when the strobe owns the shared pin. Software may always write the output register directly.

Top module: `dac_load_ctrl`

## Requirements
- R1: Reset clears the staging register, the output register and the mode field. After reset the DAC code is 0x000 and the pin enable is high, because mode 000 claims the pin.
- R2: In mode 000, a rising strobe edge copies the staging register into the output register, and the DAC code shows the output register. A falling edge, or a staging write without an edge, leaves the code unchanged.
- R3: In mode 100, a falling strobe edge copies the staging register into the output register. A rising edge has no effect.
- R4: In mode 001, a write to the staging register also loads the written value into the output register, and the DAC code shows it one clock later. Strobe edges have no effect in this mode.
- R5: Mode 011 behaves as mode 001. Modes 110 and 111 behave as mode 000.
- R6: Mode 010 performs no transfers. Neither strobe edges nor staging writes change the DAC code.
- R7: In mode 101, entering the mode leaves the DAC code at the output register value. After that, a falling strobe edge makes the code equal the staging register and a rising edge makes it equal the output register. Neither register is modified by these edges.
- R8: A direct write to the output register appears on the DAC code one clock later in every mode, except while mode 101 is selecting the staging register. In that case the written value appears after the next rising edge. A direct write takes priority over a transfer in the same cycle.
- R9: The pin enable is high for modes 000, 100, 101, 110 and 111 and low for modes 001, 010 and 011. It changes only after a mode write.
- R10: A strobe held at one level causes at most one transfer, however long it is held, even if the staging register changes meanwhile.
- R11: A strobe edge affects the DAC code on the third clock edge after the strobe changes (two synchronizer stages plus the register update), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_wr_en | input | 1 | Write strobe for the staging register |
| stg_wr_data | input | 12 | Data for the staging register |
| out_wr_en | input | 1 | Write strobe for the output register |
| out_wr_data | input | 12 | Data for the output register |
| mode_wr_en | input | 1 | Write strobe for the mode field |
| mode_wr_data | input | 3 | New mode code |
| load_in | input | 1 | Asynchronous external load strobe |
| dac_code | output | 12 | Straight-binary code to the DAC core |
| pin_alt_en | output | 1 | Gives the shared port pin to the load strobe |

## Verification
The hardest state to reach is square-wave mode after a falling edge. There the DAC code follows the staging register, and a direct output write must stay hidden until the next rising edge. The stimulus gets there in steps: it enters mode 101 with distinct values in the two registers, confirms the code still shows the output register, and then drives a falling strobe. It writes the output register while the staging value is selected, and only a later rising edge may reveal that write. The strobe is always held for the full synchronizer latency, so each check lands on a known cycle.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;

    typedef enum logic [2:0] {
        MODE_RISE        = 3'b000,
        MODE_WRITE       = 3'b001,
        MODE_IDLE        = 3'b010,
        MODE_WRITE_ALIAS = 3'b011,
        MODE_FALL        = 3'b100,
        MODE_SQUARE      = 3'b101,
        MODE_RISE_ALT_A  = 3'b110,
        MODE_RISE_ALT_B  = 3'b111
    } load_mode_e;

    typedef struct packed {
        logic on_rise;
        logic on_fall;
        logic on_write;
        logic square;
        logic pin_claim;
    } load_ctl_t;

endpackage

// File: rtl/dac_load_decode.sv
module dac_load_decode
    import dac_load_pkg::*;
(
    input  logic [2:0] mode,
    output load_ctl_t  ctl
);

    load_ctl_t ctl_d;

    always_comb begin
        ctl_d = '0;
        unique case (load_mode_e'(mode))
            MODE_RISE, MODE_RISE_ALT_A, MODE_RISE_ALT_B: ctl_d.on_rise  = 1'b1;
            MODE_WRITE, MODE_WRITE_ALIAS:                ctl_d.on_write = 1'b1;
            MODE_FALL:                                   ctl_d.on_fall  = 1'b1;
            MODE_SQUARE:                                 ctl_d.square   = 1'b1;
            MODE_IDLE:                                   ctl_d          = '0;
        endcase
        // Any mode that listens to the strobe takes the shared pin.
        ctl_d.pin_claim = ctl_d.on_rise | ctl_d.on_fall | ctl_d.square;
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/dac_load_sync.sv
module dac_load_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);

    localparam int MSB = STAGES - 1;

    logic [MSB:0] chain_d, chain_q;
    logic         last_d, last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[MSB-1:0], async_in};
        end
    endgenerate

    always_comb last_d = chain_q[MSB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            last_q  <= last_d;
        end
    end

    assign rise = chain_q[MSB] & ~last_q;
    assign fall = ~chain_q[MSB] & last_q;

endmodule

// File: rtl/dac_load_core.sv
module dac_load_core
    import dac_load_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_wr_en,
    input  logic [DATA_W-1:0] stg_wr_data,
    input  logic              out_wr_en,
    input  logic [DATA_W-1:0] out_wr_data,
    input  logic              mode_wr_en,
    input  logic [2:0]        mode_wr_data,
    input  logic              load_rise,
    input  logic              load_fall,
    input  load_ctl_t         ctl,
    output logic [2:0]        mode_q,
    output logic              sel_stg_q,
    output logic [DATA_W-1:0] code
);

    typedef struct packed {
        logic [DATA_W-1:0] stg;
        logic [DATA_W-1:0] outr;
        logic [2:0]        mode;
        logic              sel_stg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;

        if (mode_wr_en) begin
            r_d.mode    = mode_wr_data;
            r_d.sel_stg = 1'b0;
        end

        if (stg_wr_en) begin
            r_d.stg = stg_wr_data;
            if (ctl.on_write) r_d.outr = stg_wr_data;
        end

        // Edge transfers move the value held before this cycle.
        if ((ctl.on_rise && load_rise) || (ctl.on_fall && load_fall))
            r_d.outr = r_q.stg;

        if (ctl.square && !mode_wr_en) begin
            if (load_fall) r_d.sel_stg = 1'b1;
            if (load_rise) r_d.sel_stg = 1'b0;
        end

        // A direct write wins over any transfer in the same cycle.
        if (out_wr_en) r_d.outr = out_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode_q    = r_q.mode;
    assign sel_stg_q = r_q.sel_stg;
    assign code      = (ctl.square && r_q.sel_stg) ? r_q.stg : r_q.outr;

endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
    import dac_load_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_wr_en,
    input  logic [DATA_W-1:0] stg_wr_data,
    input  logic              out_wr_en,
    input  logic [DATA_W-1:0] out_wr_data,
    input  logic              mode_wr_en,
    input  logic [2:0]        mode_wr_data,
    input  logic              load_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              pin_alt_en
);

    logic      load_rise, load_fall;
    logic [2:0] mode_q;
    logic      sq_sel_stg;
    load_ctl_t ctl;

    dac_load_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (load_in),
        .rise     (load_rise),
        .fall     (load_fall)
    );

    dac_load_decode u_decode (
        .mode (mode_q),
        .ctl  (ctl)
    );

    dac_load_core #(.DATA_W(DATA_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .stg_wr_en    (stg_wr_en),
        .stg_wr_data  (stg_wr_data),
        .out_wr_en    (out_wr_en),
        .out_wr_data  (out_wr_data),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .load_rise    (load_rise),
        .load_fall    (load_fall),
        .ctl          (ctl),
        .mode_q       (mode_q),
        .sel_stg_q    (sq_sel_stg),
        .code         (dac_code)
    );

    assign pin_alt_en = ctl.pin_claim;

endmodule

// File: rtl/dac_load_ctrl_chk.sv
module dac_load_ctrl_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stg_wr_en,
    input logic [DATA_W-1:0] stg_wr_data,
    input logic              out_wr_en,
    input logic [DATA_W-1:0] out_wr_data,
    input logic              mode_wr_en,
    input logic [2:0]        mode_q,
    input logic [DATA_W-1:0] dac_code,
    input logic              pin_alt_en
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0) && pin_alt_en);

    // R4
    write_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 3'b001 || mode_q == 3'b011) && stg_wr_en && !out_wr_en && !mode_wr_en)
        |=> dac_code == $past(stg_wr_data));

    // R6
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'b010 && !out_wr_en && !mode_wr_en) |=> $stable(dac_code));

    // R8
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr_en && mode_q != 3'b101 && !mode_wr_en) |=> dac_code == $past(out_wr_data));

    // R9
    pin_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_alt_en) |-> $past(mode_wr_en));

endmodule

bind dac_load_ctrl dac_load_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stg_wr_en   (stg_wr_en),
    .stg_wr_data (stg_wr_data),
    .out_wr_en   (out_wr_en),
    .out_wr_data (out_wr_data),
    .mode_wr_en  (mode_wr_en),
    .mode_q      (mode_q),
    .dac_code    (dac_code),
    .pin_alt_en  (pin_alt_en)
);

// File: tb/dac_load_ctrl_test.sv
`timescale 1ns/1ps
module dac_load_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stg_wr_en = 1'b0;
    logic [11:0] stg_wr_data = '0;
    logic        out_wr_en = 1'b0;
    logic [11:0] out_wr_data = '0;
    logic        mode_wr_en = 1'b0;
    logic [2:0]  mode_wr_data = '0;
    logic        load_in = 1'b0;
    logic [11:0] dac_code;
    logic        pin_alt_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dac_load_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .stg_wr_en    (stg_wr_en),
        .stg_wr_data  (stg_wr_data),
        .out_wr_en    (out_wr_en),
        .out_wr_data  (out_wr_data),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .load_in      (load_in),
        .dac_code     (dac_code),
        .pin_alt_en   (pin_alt_en)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%03h expected=0x%03h", req, act, exp);
        end
    endtask

    task automatic wr_stg(input logic [11:0] v);
        stg_wr_en = 1'b1; stg_wr_data = v;
        @(negedge clk);
        stg_wr_en = 1'b0;
    endtask

    task automatic wr_out(input logic [11:0] v);
        out_wr_en = 1'b1; out_wr_data = v;
        @(negedge clk);
        out_wr_en = 1'b0;
    endtask

    task automatic wr_mode(input logic [2:0] m);
        mode_wr_en = 1'b1; mode_wr_data = m;
        @(negedge clk);
        mode_wr_en = 1'b0;
    endtask

    task automatic set_load(input logic b);
        load_in = b;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 code", dac_code, 12'h000);
        check("R1 pin", {11'b0, pin_alt_en}, 12'h001);
    endtask

    task automatic t_pin;
        for (int m = 0; m < 8; m++) begin
            wr_mode(m[2:0]);
            check("R9 pin", {11'b0, pin_alt_en}, (m == 1 || m == 2 || m == 3) ? 12'h000 : 12'h001);
        end
    endtask

    task automatic t_rise;
        wr_mode(3'b000);
        wr_stg(12'hFFF);
        check("R2 no edge", dac_code, 12'h000);
        set_load(1'b1);
        check("R2 rise", dac_code, 12'hFFF);
        wr_stg(12'h456);
        set_load(1'b0);
        check("R2 fall ignored", dac_code, 12'hFFF);
    endtask

    task automatic t_once;
        set_load(1'b1);
        check("R10 first", dac_code, 12'h456);
        wr_stg(12'h789);
        repeat (10) @(negedge clk);
        check("R10 held", dac_code, 12'h456);
        set_load(1'b0);
        check("R10 low", dac_code, 12'h456);
    endtask

    task automatic t_sync;
        wr_stg(12'hABC);
        load_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 early", dac_code, 12'h456);
        @(negedge clk);
        check("R11 third", dac_code, 12'hABC);
        set_load(1'b0);
    endtask

    task automatic t_fall;
        wr_mode(3'b100);
        wr_stg(12'h321);
        set_load(1'b1);
        check("R3 rise ignored", dac_code, 12'hABC);
        set_load(1'b0);
        check("R3 fall", dac_code, 12'h321);
    endtask

    task automatic t_write;
        wr_mode(3'b001);
        wr_stg(12'h5A5);
        check("R4 copy", dac_code, 12'h5A5);
        wr_out(12'h111);
        check("R8 direct", dac_code, 12'h111);
        set_load(1'b1);
        set_load(1'b0);
        check("R4 strobe ignored", dac_code, 12'h111);
    endtask

    task automatic t_alias;
        wr_mode(3'b011);
        wr_stg(12'h0F0);
        check("R5 011 copy", dac_code, 12'h0F0);
        wr_mode(3'b110);
        wr_stg(12'h00F);
        check("R5 110 no copy", dac_code, 12'h0F0);
        set_load(1'b1);
        check("R5 110 rise", dac_code, 12'h00F);
        set_load(1'b0);
        wr_mode(3'b111);
        wr_stg(12'hF00);
        set_load(1'b1);
        check("R5 111 rise", dac_code, 12'hF00);
        set_load(1'b0);
    endtask

    task automatic t_idle;
        wr_mode(3'b010);
        wr_stg(12'h777);
        check("R6 write", dac_code, 12'hF00);
        set_load(1'b1);
        check("R6 rise", dac_code, 12'hF00);
        set_load(1'b0);
        check("R6 fall", dac_code, 12'hF00);
    endtask

    task automatic t_square;
        wr_out(12'h200);
        wr_mode(3'b101);
        check("R7 entry", dac_code, 12'h200);
        set_load(1'b1);
        check("R7 rise", dac_code, 12'h200);
        set_load(1'b0);
        check("R7 fall", dac_code, 12'h777);
        wr_out(12'h300);
        check("R8 hidden", dac_code, 12'h777);
        set_load(1'b1);
        check("R8 revealed", dac_code, 12'h300);
        set_load(1'b0);
        check("R7 staging kept", dac_code, 12'h777);
        wr_mode(3'b010);
        check("R7 output kept", dac_code, 12'h300);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pin();
        t_rise();
        t_once();
        t_sync();
        t_fall();
        t_write();
        t_alias();
        t_idle();
        t_square();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule